// File: doc/BRIEF.md
# USB Device Power and Attach Control

This block is the small control-register slice of a USB device controller. It holds a control register and a configuration register on a plain 5-bit-address read/write bus. From their bits it drives the sideband lines around the controller: the D+ pull-up attach request, remote wake-up signalling, the low-power (suspend) request, and the oscillator wake enable. It also produces a held reset for the rest of the controller and a signal that tells the serial engine to ignore all bus traffic.

Two reset domains are kept apart. Power-on reset clears everything, including the enable bit. Ordinary system reset restores the control register and the wake logic, but leaves the enable bit alone. The VBUS and D+ inputs are asynchronous, so each one is brought in through a two-flop synchronizer. While the device is suspended, a transition on the synchronized D+ line can request an oscillator restart.

Top module: `usb_pwr_ctrl`

## Requirements
- R1: The control register is at address 02h. Its fields are bit 7 oscillator-start, bit 6 VBUS gate, bit 5 soft reset, bit 4 power-down, bit 3 attach and bit 2 wake-up signal. Either power-on reset or system reset sets it to B0h.
- R2: The configuration register is at address 03h, and bit 0 is the enable. Only power-on reset clears it to 00h. System reset and the soft-reset bit leave it unchanged.
- R3: Reserved bits read as zero whatever was written to them: bits 1:0 of the control register and bits 7:1 of the configuration register.
- R4: A write with `wr_en` high takes effect at the next rising clock edge. `rdata` is combinational from the addressed register. Any address other than 02h and 03h reads 00h.
- R5: `core_rst` is high exactly while the soft-reset bit is 1. The bit stays 1 until a write clears it, and the control register itself still accepts writes while it is set.
- R6: With VBUS gate at 0, `pullup_req` follows the attach bit. With VBUS gate at 1, `pullup_req` is high only when the attach bit is 1 and the synchronized VBUS is high. VBUS has two clock edges of synchronizer latency.
- R7: Suppose power-down and oscillator-start are both 1. A transition on `dplus_in` then raises `osc_wake` on the third rising edge after the transition. When oscillator-start is 0, `osc_wake` stays low.
- R8: If power-down or oscillator-start reads 0, `osc_wake` is low after the next edge.
- R9: `lowpwr_req` equals the power-down bit and `rwu_sig` equals the wake-up signal bit.
- R10: `core_ignore` is high whenever the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high |
| sys_rst | input | 1 | Synchronous system reset, active high |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| vbus_in | input | 1 | VBUS present, asynchronous |
| dplus_in | input | 1 | D+ line level, asynchronous |
| pullup_req | output | 1 | Request to attach the D+ pull-up |
| rwu_sig | output | 1 | Remote wake-up signalling |
| lowpwr_req | output | 1 | Low-power request |
| osc_wake | output | 1 | Oscillator wake enable |
| core_rst | output | 1 | Held reset for the other controller registers |
| core_ignore | output | 1 | Ignore all bus traffic |

## Verification
Two things can land on the same clock edge: the D+ edge detector setting the wake latch, and a register write that clears power-down. The bench provokes this by timing the write strobe so that its edge is the third edge after a D+ transition. A cycle-accurate reference model then judges the outcome on every clock: the latch sets from the old power-down value and clears one edge later. The same model also covers a system reset that arrives while the enable bit is set.

// File: rtl/usbpc_pkg.sv
package usbpc_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] CTL_ADDR = 5'h02;
    localparam logic [ADDR_W-1:0] CFG_ADDR = 5'h03;

    typedef struct packed {
        logic       osc_start;
        logic       vbus_gate;
        logic       soft_rst;
        logic       pwr_down;
        logic       attach;
        logic       wake_sig;
        logic [1:0] rsvd;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        osc_start: 1'b1, vbus_gate: 1'b0, soft_rst: 1'b1, pwr_down: 1'b1,
        attach: 1'b0, wake_sig: 1'b0, rsvd: 2'b00
    };

    function automatic ctl_t ctl_from_bus(input logic [DATA_W-1:0] d);
        ctl_t c;
        c      = ctl_t'(d);
        c.rsvd = 2'b00;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_bus(input logic en);
        return {{(DATA_W-1){1'b0}}, en};
    endfunction

endpackage

// File: rtl/usbpc_sync.sv
module usbpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/usbpc_regs.sv
module usbpc_regs
    import usbpc_pkg::*;
(
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl,
    output logic              cfg_en,
    output logic [DATA_W-1:0] rdata
);
    logic ctl_hit, cfg_hit;

    assign ctl_hit = wr_en && (addr == CTL_ADDR);
    assign cfg_hit = wr_en && (addr == CFG_ADDR);

    always_ff @(posedge clk) begin
        if (por_rst || sys_rst) ctl <= CTL_RESET;
        else if (ctl_hit)       ctl <= ctl_from_bus(wdata);
    end

    always_ff @(posedge clk) begin
        if (por_rst)      cfg_en <= 1'b0;
        else if (cfg_hit) cfg_en <= wdata[0];
    end

    always_comb begin
        case (addr)
            CTL_ADDR: rdata = ctl;
            CFG_ADDR: rdata = cfg_to_bus(cfg_en);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/usbpc_wake.sv
module usbpc_wake (
    input  logic clk,
    input  logic rst,
    input  logic dp_sync,
    input  logic pwr_down,
    input  logic osc_start,
    output logic wake
);
    logic dp_prev;
    logic dp_edge;

    always_ff @(posedge clk) begin
        if (rst) dp_prev <= 1'b0;
        else     dp_prev <= dp_sync;
    end

    assign dp_edge = dp_sync ^ dp_prev;

    always_ff @(posedge clk) begin
        if (rst)                       wake <= 1'b0;
        else if (!pwr_down || !osc_start) wake <= 1'b0;
        else if (dp_edge)              wake <= 1'b1;
    end
endmodule

// File: rtl/usb_pwr_ctrl.sv
module usb_pwr_ctrl
    import usbpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              vbus_in,
    input  logic              dplus_in,
    output logic              pullup_req,
    output logic              rwu_sig,
    output logic              lowpwr_req,
    output logic              osc_wake,
    output logic              core_rst,
    output logic              core_ignore
);
    localparam int NSYNC = 2;

    ctl_t             ctl_q;
    logic             cfg_en;
    logic [NSYNC-1:0] async_in, sync_out;
    logic             vbus_s, dp_s, side_rst;

    assign side_rst = por_rst || sys_rst;
    assign async_in = {dplus_in, vbus_in};
    assign vbus_s   = sync_out[0];
    assign dp_s     = sync_out[1];

    usbpc_regs u_regs (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .ctl(ctl_q), .cfg_en(cfg_en), .rdata(rdata)
    );

    usbpc_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(side_rst), .din(async_in), .dout(sync_out)
    );

    usbpc_wake u_wake (
        .clk(clk), .rst(side_rst), .dp_sync(dp_s), .pwr_down(ctl_q.pwr_down),
        .osc_start(ctl_q.osc_start), .wake(osc_wake)
    );

    assign pullup_req  = ctl_q.attach && (!ctl_q.vbus_gate || vbus_s);
    assign rwu_sig     = ctl_q.wake_sig;
    assign lowpwr_req  = ctl_q.pwr_down;
    assign core_rst    = ctl_q.soft_rst;
    assign core_ignore = !cfg_en;
endmodule

// File: rtl/usbpc_chk.sv
module usbpc_chk (
    input logic       clk,
    input logic       por_rst,
    input logic       sys_rst,
    input logic       wr_en,
    input logic [4:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] ctl,
    input logic       cfg_en,
    input logic       vbus_s,
    input logic       pullup_req,
    input logic       osc_wake,
    input logic       core_rst
);
    a_r1_sysrst_value: assert property (@(posedge clk) disable iff (por_rst)
        sys_rst |=> (ctl == 8'hB0));

    a_r2_cfg_holds: assert property (@(posedge clk) disable iff (por_rst)
        !(wr_en && addr == 5'h03) |=> $stable(cfg_en));

    a_r3_ctl_rsvd: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        (addr == 5'h02) |-> (rdata[1:0] == 2'b00));

    a_r3_cfg_rsvd: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        (addr == 5'h03) |-> (rdata[7:1] == 7'd0));

    a_r5_clear_by_write: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        $fell(core_rst) |-> ($past(wr_en) && $past(addr) == 5'h02 && !$past(wdata[5])));

    a_r6_gate_needs_vbus: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        (ctl[6] && pullup_req) |-> vbus_s);

    a_r6_no_attach: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        !ctl[3] |-> !pullup_req);

    a_r7_wake_cause: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        $rose(osc_wake) |-> ($past(ctl[4]) && $past(ctl[7])));

    a_r8_wake_clears: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        (!ctl[4] || !ctl[7]) |=> !osc_wake);
endmodule

bind usb_pwr_ctrl usbpc_chk u_chk (
    .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ctl(ctl_q), .cfg_en(cfg_en),
    .vbus_s(vbus_s), .pullup_req(pullup_req), .osc_wake(osc_wake),
    .core_rst(core_rst)
);

// File: tb/tb_usb_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_usb_pwr_ctrl;
    logic       clk = 1'b0;
    logic       por_rst = 1'b1, sys_rst = 1'b0, wr_en = 1'b0;
    logic [4:0] addr = 5'h00;
    logic [7:0] wdata = 8'h00;
    logic       vbus_in = 1'b0, dplus_in = 1'b0;
    logic [7:0] rdata;
    logic       pullup_req, rwu_sig, lowpwr_req, osc_wake, core_rst, core_ignore;

    int checks = 0;
    int errors = 0;
    bit started = 0;

    always #4 clk = ~clk;

    usb_pwr_ctrl dut (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .vbus_in(vbus_in),
        .dplus_in(dplus_in), .pullup_req(pullup_req), .rwu_sig(rwu_sig),
        .lowpwr_req(lowpwr_req), .osc_wake(osc_wake), .core_rst(core_rst),
        .core_ignore(core_ignore)
    );

    // Behavioural reference: register images plus delay queues for the async inputs
    bit [7:0] m_ctl, m_cfg;
    bit       m_wake;
    bit       vbus_q[$];
    bit       dp_q[$];

    task automatic clear_pipes();
        vbus_q = '{0, 0};
        dp_q   = '{0, 0, 0};
    endtask

    always @(posedge clk) begin
        if (por_rst) m_cfg = 8'h00;
        else if (wr_en && addr == 5'h03) m_cfg = wdata & 8'h01;
        if (por_rst || sys_rst) begin
            m_ctl  = 8'hB0;
            m_wake = 0;
            clear_pipes();
        end else begin
            if (!m_ctl[4] || !m_ctl[7]) m_wake = 0;
            else if (dp_q[1] != dp_q[2]) m_wake = 1;
            void'(dp_q.pop_back());
            dp_q.push_front(dplus_in);
            void'(vbus_q.pop_back());
            vbus_q.push_front(vbus_in);
            if (wr_en && addr == 5'h02) m_ctl = wdata & 8'hFC;
        end
        started = 1;
    end

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (started) begin
            bit [7:0] exp_rd;
            exp_rd = (addr == 5'h02) ? m_ctl : (addr == 5'h03) ? m_cfg : 8'h00;
            cmp("R4", "rdata", rdata, exp_rd);
            cmp("R6", "pullup_req", pullup_req, m_ctl[3] && (!m_ctl[6] || vbus_q[1]));
            cmp("R9", "rwu_sig", rwu_sig, m_ctl[2]);
            cmp("R9", "lowpwr_req", lowpwr_req, m_ctl[4]);
            cmp("R7", "osc_wake", osc_wake, m_wake);
            cmp("R5", "core_rst", core_rst, m_ctl[5]);
            cmp("R10", "core_ignore", core_ignore, !m_cfg[0]);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [4:0] a);
        @(negedge clk);
        addr = a;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        por_rst = 0;
        // R1 reset value, R2 cleared enable
        rd(5'h02); cyc(1); rd(5'h03); cyc(1);
        // R2, R3: enable set, reserved bits dropped
        wr(5'h03, 8'hFF); cyc(1);
        wr(5'h02, 8'hFF); rd(5'h02); cyc(1);
        // R4 unmapped addresses
        rd(5'h00); rd(5'h05); rd(5'h1F); cyc(1);
        // R5: soft reset cleared only by write; enable kept meanwhile
        wr(5'h02, 8'hB0); wr(5'h03, 8'h01); rd(5'h03); cyc(1);
        wr(5'h02, 8'h90); rd(5'h02); cyc(2);
        // R1, R2: system reset restores control, keeps enable
        @(negedge clk); sys_rst = 1; @(negedge clk); sys_rst = 0;
        rd(5'h03); cyc(1); rd(5'h02); cyc(1);
        // R6: attach ungated, then gated by VBUS
        wr(5'h02, 8'h08); cyc(2);
        wr(5'h02, 8'h48); cyc(3);
        @(negedge clk); vbus_in = 1; cyc(4);
        @(negedge clk); vbus_in = 0; cyc(4);
        wr(5'h02, 8'h0C); cyc(2);
        // R7: wake on D+ transition while suspended
        wr(5'h02, 8'h90); cyc(2);
        @(negedge clk); dplus_in = 1; cyc(5);
        // R8: clearing power-down drops wake
        wr(5'h02, 8'h80); cyc(2);
        // R7: oscillator-start clear inhibits wake
        wr(5'h02, 8'h10); cyc(2);
        @(negedge clk); dplus_in = 0; cyc(5);
        // Concurrent: write clearing power-down on the detection edge
        wr(5'h02, 8'h90); cyc(3);
        @(negedge clk); dplus_in = 1;
        @(negedge clk);
        wr(5'h02, 8'h80); cyc(3);
        // Concurrent: system reset while enable set and wake latched
        wr(5'h02, 8'h90); cyc(1);
        @(negedge clk); dplus_in = 0; cyc(4);
        @(negedge clk); sys_rst = 1; wr_en = 1; addr = 5'h03; wdata = 8'h00;
        @(negedge clk); sys_rst = 0; wr_en = 0; cyc(2);
        // R2: power-on reset clears enable
        @(negedge clk); por_rst = 1; cyc(2); por_rst = 0; rd(5'h03); cyc(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule